// File: doc/BRIEF.md
# Buffered Serial Transmitter with Stage Flags

This block is the transmit half of an asynchronous serial port. A one-byte holding register sits in front of a separate frame shifter. Software can therefore queue the next byte while the current frame is still on the line. The bit rate comes from an external divider, which supplies a one-cycle `bit_tick` enable in the system clock domain. Every line transition happens on a clock edge where that enable is high.

Three flags report the state of each stage:

- `buf_empty` shows that the holding register is free.
- `shift_busy` shows that a frame is on the line.
- `tx_end` is sticky. It records that the shifter has gone idle and stays set until it is cleared with a write-1 strobe.

`buf_empty` and `tx_end` each drive their own interrupt request, and each request is gated by its own enable input. The frame may carry an optional parity bit, even or odd. The format inputs are meant to change only while `tx_en` is low.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, and `shift_busy`, `tx_end`, `irq_empty` and `irq_end` are all 0 (both interrupt enables low).
- R2: A frame is a 0 start bit, then the eight data bits with bit 0 first, then a 1 stop bit. When `par_en` is 0, no parity bit is sent.
- R3: When `par_en` is 1, a parity bit goes between data bit 7 and the stop bit. With `par_odd` at 0, the nine bits have an even count of ones. With `par_odd` at 1, the count is odd.
- R4: `txd` changes only on clock edges where `bit_tick` is high, except on a disable. Each bit therefore lasts exactly one tick period.
- R5: A write (`wr_stb` high while `tx_en` is 1) makes `buf_empty` 0 after that edge. `buf_empty` returns to 1 on the tick edge that moves the byte into the shifter.
- R6: A write while `buf_empty` is 0 replaces the held byte. Only the newest byte is sent.
- R7: `shift_busy` rises on the tick edge that loads the shifter and falls on the tick edge that ends the stop bit. If a byte is held when a stop bit ends, that byte's start bit follows with no idle bit time, and `shift_busy` stays 1.
- R8: `tx_end` becomes 1 on the clock after `shift_busy` falls and holds until `end_clr` is pulsed. If the set and the clear arrive in the same cycle, the set wins.
- R9: `irq_empty` equals `buf_empty` AND `irq_empty_en`. `irq_end` equals `tx_end` AND `irq_end_en`.
- R10: When `tx_en` is 0, the next clock leaves `shift_busy` at 0, `buf_empty` at 1 and `txd` at 1. Writes made while `tx_en` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-rate enable from the external divider |
| tx_en | input | 1 | Transmitter enable |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to queue |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| end_clr | input | 1 | Write-1 clear of the end flag |
| irq_empty_en | input | 1 | Enable for the buffer-free request |
| irq_end_en | input | 1 | Enable for the end-of-transmission request |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding register free |
| shift_busy | output | 1 | Frame in progress |
| tx_end | output | 1 | Sticky end-of-transmission flag |
| irq_empty | output | 1 | Buffer-free interrupt request |
| irq_end | output | 1 | End-of-transmission interrupt request |

## Verification
The end flag's set, caused by `shift_busy` falling, and its software clear can land in the same clock cycle. The bench provokes this by watching at the falling clock edge for the first cycle in which `shift_busy` reads 0 after a frame, and pulsing `end_clr` in exactly that cycle. It then judges that `tx_end` reads 1 afterwards (the set wins), and that a later lone pulse clears it. A second overlap, between a stop bit ending and a held byte loading, is judged by requiring zero idle bit samples between two frames and `tx_end` staying 0 across the boundary.

// File: rtl/uart_tx_hold_pkg.sv
`timescale 1ns/1ps
package uart_tx_hold_pkg;
  parameter int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = BYTE_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  // parity bit that completes the requested count of ones
  function automatic logic parity_of(input logic [BYTE_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // line image, bit 0 leaves first; unused parity slot doubles as stop
  function automatic logic [FRAME_W-1:0] frame_of(input logic [BYTE_W-1:0] d,
                                                  input logic pen, input logic odd);
    return {1'b1, (pen ? parity_of(d, odd) : 1'b1), d, 1'b0};
  endfunction

  // index of the stop bit within the frame image
  function automatic logic [CNT_W-1:0] stop_index(input logic pen);
    return pen ? CNT_W'(BYTE_W + 2) : CNT_W'(BYTE_W + 1);
  endfunction
endpackage

// File: rtl/uart_tx_hold_buf.sv
`timescale 1ns/1ps
module uart_tx_hold_buf
  import uart_tx_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load_evt,
  output logic              hold_full,
  output logic [BYTE_W-1:0] hold_byte
);
  // a write in the load cycle keeps the new byte; the shifter takes the old one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_byte <= '0;
    end else if (!tx_en) begin
      hold_full <= 1'b0;
    end else if (wr_stb) begin
      hold_full <= 1'b1;
      hold_byte <= wr_data;
    end else if (load_evt) begin
      hold_full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_hold_shift.sv
`timescale 1ns/1ps
module uart_tx_hold_shift
  import uart_tx_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              hold_full,
  input  logic [BYTE_W-1:0] hold_byte,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              load_evt,
  output logic              shift_busy,
  output logic              txd
);
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   idx;
  logic [CNT_W-1:0]   last_idx;
  logic               busy_q;
  logic               at_stop;

  assign at_stop  = busy_q && (idx == last_idx);
  // load only on a tick: from idle, or straight after a stop bit
  assign load_evt = tx_en && bit_tick && hold_full && (!busy_q || at_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sreg     <= '1;
      idx      <= '0;
      last_idx <= '0;
    end else if (!tx_en) begin
      busy_q <= 1'b0;
      sreg   <= '1;
      idx    <= '0;
    end else if (load_evt) begin
      busy_q   <= 1'b1;
      sreg     <= frame_of(hold_byte, par_en, par_odd);
      idx      <= '0;
      last_idx <= stop_index(par_en);
    end else if (bit_tick && busy_q) begin
      if (at_stop) begin
        busy_q <= 1'b0;
        sreg   <= '1;
        idx    <= '0;
      end else begin
        sreg <= {1'b1, sreg[FRAME_W-1:1]};
        idx  <= idx + 1'b1;
      end
    end
  end

  assign shift_busy = busy_q;
  assign txd        = busy_q ? sreg[0] : 1'b1;
endmodule

// File: rtl/uart_tx_hold_flags.sv
`timescale 1ns/1ps
module uart_tx_hold_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_busy,
  input  logic hold_full,
  input  logic end_clr,
  input  logic irq_empty_en,
  input  logic irq_end_en,
  output logic busy_fall,
  output logic buf_empty,
  output logic tx_end,
  output logic irq_empty,
  output logic irq_end
);
  logic busy_prev;

  assign busy_fall = busy_prev && !shift_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev <= 1'b0;
      tx_end    <= 1'b0;
    end else begin
      busy_prev <= shift_busy;
      if (busy_fall)    tx_end <= 1'b1;
      else if (end_clr) tx_end <= 1'b0;
    end
  end

  assign buf_empty = !hold_full;
  assign irq_empty = buf_empty && irq_empty_en;
  assign irq_end   = tx_end && irq_end_en;
endmodule

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold
  import uart_tx_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              end_clr,
  input  logic              irq_empty_en,
  input  logic              irq_end_en,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_busy,
  output logic              tx_end,
  output logic              irq_empty,
  output logic              irq_end
);
  logic              load_evt;
  logic              busy_fall;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_byte;

  uart_tx_hold_buf buf_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .load_evt(load_evt), .hold_full(hold_full), .hold_byte(hold_byte)
  );

  uart_tx_hold_shift shift_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .hold_full(hold_full), .hold_byte(hold_byte), .par_en(par_en), .par_odd(par_odd),
    .load_evt(load_evt), .shift_busy(shift_busy), .txd(txd)
  );

  uart_tx_hold_flags flags_i (
    .clk(clk), .rst_n(rst_n), .shift_busy(shift_busy), .hold_full(hold_full),
    .end_clr(end_clr), .irq_empty_en(irq_empty_en), .irq_end_en(irq_end_en),
    .busy_fall(busy_fall), .buf_empty(buf_empty), .tx_end(tx_end),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );
endmodule

// File: rtl/uart_tx_hold_chk.sv
`timescale 1ns/1ps
module uart_tx_hold_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_en,
  input logic wr_stb,
  input logic end_clr,
  input logic txd,
  input logic buf_empty,
  input logic shift_busy,
  input logic tx_end,
  input logic load_evt,
  input logic busy_fall
);
  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($past(bit_tick) || !$past(tx_en))); // R4
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stb && tx_en) |-> !buf_empty); // R5
  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_busy) |-> $past(bit_tick)); // R7
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && shift_busy) |=> shift_busy); // R7
  AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_busy) |=> tx_end); // R8
  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && !end_clr) |=> tx_end); // R8
  AST_END_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && end_clr && !busy_fall) |=> !tx_end); // R8
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!shift_busy && buf_empty && txd)); // R10
endmodule

bind uart_tx_hold uart_tx_hold_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .wr_stb(wr_stb),
  .end_clr(end_clr), .txd(txd), .buf_empty(buf_empty), .shift_busy(shift_busy),
  .tx_end(tx_end), .load_evt(load_evt), .busy_fall(busy_fall)
);

// File: tb/uart_tx_hold_tb_top.sv
`timescale 1ns/1ps
module uart_tx_hold_tb_top;
  logic clk = 1'b0;
  logic rst_n, bit_tick, tx_en, wr_stb, par_en, par_odd, end_clr;
  logic irq_empty_en, irq_end_en;
  logic [7:0] wr_data;
  logic txd, buf_empty, shift_busy, tx_end, irq_empty, irq_end;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int rx_state = 0, rx_nb = 0, rx_idle = 0, rx_cnt = 0;
  logic [7:0] rx_cur;
  logic [7:0] rx_byte [0:1023];
  logic       rx_par  [0:1023];
  logic       rx_stop [0:1023];
  int         rx_gap  [0:1023];
  logic       cur_par;

  always #4 clk = ~clk;

  uart_tx_hold dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .par_en(par_en), .par_odd(par_odd), .end_clr(end_clr),
    .irq_empty_en(irq_empty_en), .irq_end_en(irq_end_en), .txd(txd),
    .buf_empty(buf_empty), .shift_busy(shift_busy), .tx_end(tx_end),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // bench receiver: one sample per tick edge, taken at the following falling edge
  task automatic rx_sample();
    case (rx_state)
      0: if (txd == 1'b0) begin
           rx_gap[rx_cnt] = rx_idle; rx_idle = 0; rx_nb = 0; rx_state = 1;
         end else rx_idle++;
      1: begin
           rx_cur[rx_nb] = txd; rx_nb++;
           if (rx_nb == 8) rx_state = par_en ? 2 : 3;
         end
      2: begin cur_par = txd; rx_state = 3; end
      default: begin
           rx_byte[rx_cnt] = rx_cur; rx_par[rx_cnt] = cur_par;
           rx_stop[rx_cnt] = txd; rx_cnt++; rx_state = 0;
         end
    endcase
  endtask

  initial begin
    bit_tick = 1'b0;
    for (int t = 0; ; t++) begin
      @(negedge clk);
      if (bit_tick && rst_n) rx_sample();
      bit_tick = ((t % 4) == 3);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    report();
  end

  task automatic do_write(input logic [7:0] b);
    @(negedge clk); wr_stb = 1'b1; wr_data = b;
    @(negedge clk); wr_stb = 1'b0;
    if (tx_en) chk(buf_empty == 1'b0, "R5", "buffer empty after write", buf_empty, 0);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!shift_busy && buf_empty) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_loaded();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (buf_empty) break;
    end
  endtask

  task automatic clear_end();
    @(negedge clk); end_clr = 1'b1;
    @(negedge clk); end_clr = 1'b0;
  endtask

  initial begin
    int base;
    logic exp_par;
    rst_n = 1'b0; tx_en = 1'b0; wr_stb = 1'b0; wr_data = '0; par_en = 1'b0;
    par_odd = 1'b0; end_clr = 1'b0; irq_empty_en = 1'b0; irq_end_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd idle", txd, 1);
    chk(buf_empty == 1'b1, "R1", "buf_empty", buf_empty, 1);
    chk(shift_busy == 1'b0, "R1", "shift_busy", shift_busy, 0);
    chk(tx_end == 1'b0, "R1", "tx_end", tx_end, 0);
    chk(irq_empty == 1'b0 && irq_end == 1'b0, "R1", "irqs", irq_empty + irq_end, 0);
    irq_empty_en = 1'b1; irq_end_en = 1'b1; tx_en = 1'b1;
    @(negedge clk);
    chk(irq_empty == 1'b1, "R9", "irq_empty with empty buffer", irq_empty, 1);

    // R2/R3 sweep of every byte under three formats
    for (int cfg = 0; cfg < 3; cfg++) begin
      @(negedge clk); tx_en = 1'b0;
      par_en = (cfg != 0); par_odd = (cfg == 2);
      @(negedge clk); tx_en = 1'b1;
      for (int b = 0; b < 256; b++) begin
        base = rx_cnt;
        do_write(b[7:0]);
        if (b == 0) chk(irq_empty == 1'b0, "R9", "irq_empty with full buffer", irq_empty, 0);
        wait_idle();
        chk(rx_cnt == base + 1, "R2", "frame count", rx_cnt, base + 1);
        chk(rx_byte[base] == b[7:0], "R2", "data byte", rx_byte[base], b);
        chk(rx_stop[base] == 1'b1, "R2", "stop bit", rx_stop[base], 1);
        if (par_en) begin
          exp_par = (^b[7:0]) ^ par_odd;
          chk(rx_par[base] == exp_par, "R3", "parity bit", rx_par[base], exp_par);
        end
        chk(tx_end == 1'b1, "R8", "end flag after frame", tx_end, 1);
        chk(irq_end == 1'b1, "R9", "irq_end", irq_end, 1);
        if (b == 5) begin
          irq_end_en = 1'b0; @(negedge clk);
          chk(irq_end == 1'b0, "R9", "irq_end masked", irq_end, 0);
          repeat (30) @(negedge clk);
          chk(tx_end == 1'b1, "R8", "end flag sticky", tx_end, 1);
          irq_end_en = 1'b1;
        end
        clear_end();
        chk(tx_end == 1'b0, "R8", "end flag cleared", tx_end, 0);
      end
    end

    // R7 back-to-back frames: no idle gap, busy held, no end flag between
    @(negedge clk); tx_en = 1'b0; par_en = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    base = rx_cnt;
    do_write(8'h3C);
    wait_loaded();
    do_write(8'hC3);
    wait_loaded();
    chk(shift_busy == 1'b1, "R7", "busy across frames", shift_busy, 1);
    chk(tx_end == 1'b0, "R7", "no end flag between frames", tx_end, 0);
    wait_idle();
    chk(rx_cnt == base + 2, "R7", "two frames", rx_cnt, base + 2);
    chk(rx_byte[base + 1] == 8'hC3, "R7", "second byte", rx_byte[base + 1], 8'hC3);
    chk(rx_gap[base + 1] == 0, "R7", "idle bits between frames", rx_gap[base + 1], 0);
    clear_end();

    // R6 overwrite of a full buffer
    base = rx_cnt;
    do_write(8'h11);
    wait_loaded();
    do_write(8'h22);
    do_write(8'h33);
    wait_idle();
    chk(rx_cnt == base + 2, "R6", "frames after overwrite", rx_cnt, base + 2);
    chk(rx_byte[base] == 8'h11, "R6", "first byte", rx_byte[base], 8'h11);
    chk(rx_byte[base + 1] == 8'h33, "R6", "replacement byte", rx_byte[base + 1], 8'h33);
    clear_end();

    // R8 set and clear in the same cycle: set wins
    do_write(8'h5A);
    for (int k = 0; k < 4000; k++) begin @(negedge clk); if (shift_busy) break; end
    for (int k = 0; k < 4000; k++) begin @(negedge clk); if (!shift_busy) break; end
    end_clr = 1'b1;
    @(negedge clk); end_clr = 1'b0;
    chk(tx_end == 1'b1, "R8", "set wins over clear", tx_end, 1);
    clear_end();
    chk(tx_end == 1'b0, "R8", "later clear", tx_end, 0);

    // R10 disable mid-frame, then writes while disabled
    do_write(8'h44);
    wait_loaded();
    do_write(8'h55);
    repeat (6) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(shift_busy == 1'b0, "R10", "busy after disable", shift_busy, 0);
    chk(buf_empty == 1'b1, "R10", "buffer after disable", buf_empty, 1);
    chk(txd == 1'b1, "R10", "txd after disable", txd, 1);
    do_write(8'h66);
    chk(buf_empty == 1'b1, "R10", "write ignored when disabled", buf_empty, 1);
    begin
      bit line_ok = 1'b1;
      for (int k = 0; k < 40; k++) begin @(negedge clk); if (txd !== 1'b1) line_ok = 1'b0; end
      chk(line_ok, "R10", "line idle while disabled", line_ok, 1);
    end
    rx_state = 0;
    clear_end();
    base = rx_cnt;
    tx_en = 1'b1;
    begin
      bit idle_ok = 1'b1;
      for (int k = 0; k < 60; k++) begin @(negedge clk); if (shift_busy) idle_ok = 1'b0; end
      chk(idle_ok, "R10", "ignored byte not sent", idle_ok, 1);
    end
    chk(rx_cnt == base, "R10", "no frame after enable", rx_cnt, base);
    chk(tx_end == 1'b0, "R8", "end flag stays clear", tx_end, 0);
    report();
  end
endmodule